// File: doc/BRIEF.md
# I2C Transfer Control Register

This block is the transfer control register of an I2C controller. It holds the target address, the transfer direction, the 10-bit addressing options, the byte count and two end-of-transfer mode bits. It also holds four command bits: start request, stop request, NACK request and PEC request. Software sets a command bit by writing 1 to it. Hardware clears it when the matching protocol event arrives. Writing 0 to a command bit leaves it as it is.

The protocol engine signals each clearing event with a one-cycle pulse. While a start request is pending, the engine is using the addressing and count fields, so writes to those fields are dropped. The two mode bits stay writable at all times. A build parameter selects whether PEC support exists. Without it, the PEC request bit always reads 0.

Register layout, LSB first, with the default widths: address bits 9..0, direction bit 10 (1 = read), 10-bit mode bit 11, header-only-read bit 12, byte count bits 20..13, reload bit 21, auto-end bit 22, start bit 23, stop bit 24, NACK bit 25, PEC bit 26.

Top module: `i2c_xfer_ctrl_reg`

## Requirements
- R1: After reset, every field and every command bit reads 0.
- R2: A write sets a command bit (start 23, stop 24, NACK 25, PEC 26) when the written bit is 1. When the written bit is 0, the command bit keeps its value.
- R3: The start bit clears one cycle after any of these pulses: address sent, arbitration lost, timeout, or start-clear command.
- R4: The stop bit clears one cycle after a stop-detected pulse.
- R5: The NACK bit clears one cycle after a NACK-sent, stop-detected or address-matched pulse.
- R6: The PEC bit clears one cycle after a PEC-done, stop-detected or address-matched pulse.
- R7: While the peripheral enable is low, all four command bits are 0, and a write of 1 to any of them does not set it.
- R8: While the start bit is 1, writes leave the address, direction, 10-bit mode, header-only-read and byte count fields unchanged.
- R9: While the start bit is 0, a write updates every configuration field. The reload and auto-end bits take writes even while the start bit is 1.
- R10: When a clearing pulse and a write of 1 to the same command bit arrive in the same cycle, the bit ends up 0.
- R11: When PEC support is off, the PEC bit reads 0 even after a write of 1.
- R12: The readback word always shows the current value of every field, at the bit positions given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 27 | Write data, in the register layout |
| periph_en | input | 1 | Peripheral enable; low clears the command bits |
| ev_addr_sent | input | 1 | Pulse: start and address sequence sent |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_timeout | input | 1 | Pulse: timeout detected |
| ev_start_clr | input | 1 | Pulse: software start-clear command |
| ev_stop_det | input | 1 | Pulse: stop condition detected |
| ev_addr_match | input | 1 | Pulse: own address matched |
| ev_nack_sent | input | 1 | Pulse: NACK sent |
| ev_pec_done | input | 1 | Pulse: PEC byte transferred |
| addr_o | output | 10 | Target address |
| dir_rd_o | output | 1 | Direction, 1 = read |
| ten_bit_o | output | 1 | 10-bit addressing mode |
| head_only_o | output | 1 | Send only the 10-bit header for a read |
| count_o | output | 8 | Byte count |
| reload_o | output | 1 | Reload the byte count after the count completes |
| auto_end_o | output | 1 | Send a stop automatically at the end of the count |
| start_o | output | 1 | Start request pending |
| stop_o | output | 1 | Stop request pending |
| nack_o | output | 1 | NACK request pending |
| pec_o | output | 1 | PEC request pending |
| rd_data | output | 27 | Readback word |

## Verification
A software write of 1 and a hardware clearing pulse for the same command bit can fall in the same cycle. A configuration write can also coincide with a pending start. The bench provokes the first case by driving the write strobe and a timeout pulse (and, separately, a stop-detected pulse) on the same falling edge. The bit must read 0 afterwards. It provokes the second case by writing new configuration while start is set. The locked fields must hold their old values while the reload and auto-end bits take the new ones.

// File: rtl/i2c_xcr_pkg.sv
package i2c_xcr_pkg;
   typedef enum int {
      CMD_START = 0,
      CMD_STOP  = 1,
      CMD_NACK  = 2,
      CMD_PEC   = 3
   } cmd_idx_e;

   localparam int CMD_N = 4;
endpackage

// File: rtl/i2c_xcr_cmd_bit.sv
// Single command bit: set by a write of 1, cleared by hardware; clear dominates.
module i2c_xcr_cmd_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (clr_i) q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
   end
endmodule

// File: rtl/i2c_xcr_cfg_field.sv
// Configuration field: loads on a write unless locked.
module i2c_xcr_cfg_field #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         lock,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              q <= '0;
      else if (wr_en && !lock) q <= d;
   end
endmodule

// File: rtl/i2c_xfer_ctrl_reg.sv
module i2c_xfer_ctrl_reg #(
   parameter int ADDR_W      = 10,
   parameter int CNT_W       = 8,
   parameter bit PEC_SUPPORT = 1'b1,
   localparam int REG_W      = ADDR_W + CNT_W + 5 + i2c_xcr_pkg::CMD_N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             periph_en,
   input  logic             ev_addr_sent,
   input  logic             ev_arb_lost,
   input  logic             ev_timeout,
   input  logic             ev_start_clr,
   input  logic             ev_stop_det,
   input  logic             ev_addr_match,
   input  logic             ev_nack_sent,
   input  logic             ev_pec_done,
   output logic [ADDR_W-1:0] addr_o,
   output logic             dir_rd_o,
   output logic             ten_bit_o,
   output logic             head_only_o,
   output logic [CNT_W-1:0] count_o,
   output logic             reload_o,
   output logic             auto_end_o,
   output logic             start_o,
   output logic             stop_o,
   output logic             nack_o,
   output logic             pec_o,
   output logic [REG_W-1:0] rd_data
);
   import i2c_xcr_pkg::*;

   localparam int OFF_DIR  = ADDR_W;
   localparam int OFF_TEN  = ADDR_W + 1;
   localparam int OFF_HEAD = ADDR_W + 2;
   localparam int OFF_CNT  = ADDR_W + 3;
   localparam int OFF_RLD  = OFF_CNT + CNT_W;
   localparam int OFF_AUTO = OFF_RLD + 1;
   localparam int OFF_CMD  = OFF_AUTO + 1;
   localparam int LOCK_W   = OFF_RLD;
   localparam int FREE_W   = OFF_CMD - OFF_RLD;

   generate
      if (ADDR_W < 10) begin : g_bad_addr
         $error("ADDR_W must be at least 10");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must be 1..16");
      end
   endgenerate

   logic [CMD_N-1:0]  cmd_q, cmd_set, cmd_clr;
   logic [LOCK_W-1:0] lock_q;
   logic [FREE_W-1:0] free_q;

   // Configuration: fields used by the address phase freeze while start is pending
   i2c_xcr_cfg_field #(.W(LOCK_W)) u_lock_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lock(cmd_q[CMD_START]),
      .d(wr_data[LOCK_W-1:0]), .q(lock_q)
   );

   i2c_xcr_cfg_field #(.W(FREE_W)) u_free_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lock(1'b0),
      .d(wr_data[OFF_CMD-1:OFF_RLD]), .q(free_q)
   );

   // Hardware clear sources, one per command bit
   always_comb begin
      cmd_clr            = '0;
      cmd_clr[CMD_START] = ev_addr_sent | ev_arb_lost | ev_timeout | ev_start_clr;
      cmd_clr[CMD_STOP]  = ev_stop_det;
      cmd_clr[CMD_NACK]  = ev_nack_sent | ev_stop_det | ev_addr_match;
      cmd_clr[CMD_PEC]   = ev_pec_done | ev_stop_det | ev_addr_match;
      if (!periph_en) cmd_clr = '1;
   end

   assign cmd_set = {CMD_N{wr_en}} & wr_data[OFF_CMD +: CMD_N];

   generate
      for (genvar i = 0; i < CMD_N; i++) begin : g_cmd
         if (i == CMD_PEC && !PEC_SUPPORT) begin : g_tied
            assign cmd_q[i] = 1'b0;
         end else begin : g_bit
            i2c_xcr_cmd_bit u_bit (
               .clk(clk), .rst_n(rst_n), .set_i(cmd_set[i]), .clr_i(cmd_clr[i]),
               .q_o(cmd_q[i])
            );
         end
      end
   endgenerate

   assign addr_o      = lock_q[ADDR_W-1:0];
   assign dir_rd_o    = lock_q[OFF_DIR];
   assign ten_bit_o   = lock_q[OFF_TEN];
   assign head_only_o = lock_q[OFF_HEAD];
   assign count_o     = lock_q[OFF_CNT +: CNT_W];
   assign reload_o    = free_q[0];
   assign auto_end_o  = free_q[1];
   assign start_o     = cmd_q[CMD_START];
   assign stop_o      = cmd_q[CMD_STOP];
   assign nack_o      = cmd_q[CMD_NACK];
   assign pec_o       = cmd_q[CMD_PEC];

   assign rd_data = {cmd_q, free_q, lock_q};
endmodule

// File: rtl/i2c_xfer_ctrl_reg_chk.sv
module i2c_xfer_ctrl_reg_chk #(
   parameter int ADDR_W = 10,
   parameter int CNT_W  = 8,
   parameter int REG_W  = 27
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [REG_W-1:0]  wr_data,
   input logic              periph_en,
   input logic              ev_addr_sent,
   input logic              ev_arb_lost,
   input logic              ev_timeout,
   input logic              ev_start_clr,
   input logic              ev_stop_det,
   input logic              ev_addr_match,
   input logic              ev_nack_sent,
   input logic              ev_pec_done,
   input logic [ADDR_W-1:0] addr_o,
   input logic              dir_rd_o,
   input logic              ten_bit_o,
   input logic              head_only_o,
   input logic [CNT_W-1:0]  count_o,
   input logic              start_o,
   input logic              stop_o,
   input logic              nack_o,
   input logic              pec_o
);
   localparam int STOP_BIT = ADDR_W + CNT_W + 6;

   AST_ZERO_WRITE_KEEPS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_o && wr_en && !wr_data[STOP_BIT] && periph_en && !ev_stop_det) |=> stop_o); // R2
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_addr_sent || ev_arb_lost || ev_timeout || ev_start_clr) |=> !start_o); // R3
   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop_det |=> !stop_o); // R4
   AST_NACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_nack_sent || ev_stop_det || ev_addr_match) |=> !nack_o); // R5
   AST_PEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_pec_done || ev_stop_det || ev_addr_match) |=> !pec_o); // R6
   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !periph_en |=> !(start_o || stop_o || nack_o || pec_o)); // R7
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> $stable({addr_o, dir_rd_o, ten_bit_o, head_only_o, count_o})); // R8
endmodule

bind i2c_xfer_ctrl_reg i2c_xfer_ctrl_reg_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .periph_en(periph_en),
   .ev_addr_sent(ev_addr_sent), .ev_arb_lost(ev_arb_lost), .ev_timeout(ev_timeout),
   .ev_start_clr(ev_start_clr), .ev_stop_det(ev_stop_det), .ev_addr_match(ev_addr_match),
   .ev_nack_sent(ev_nack_sent), .ev_pec_done(ev_pec_done),
   .addr_o(addr_o), .dir_rd_o(dir_rd_o), .ten_bit_o(ten_bit_o), .head_only_o(head_only_o),
   .count_o(count_o), .start_o(start_o), .stop_o(stop_o), .nack_o(nack_o), .pec_o(pec_o)
);

// File: tb/i2c_xfer_ctrl_reg_tb.sv
`timescale 1ns/1ps
module i2c_xfer_ctrl_reg_tb;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [26:0] wr_data = '0;
   logic        periph_en = 1'b1;
   logic ev_addr_sent = 0, ev_arb_lost = 0, ev_timeout = 0, ev_start_clr = 0;
   logic ev_stop_det = 0, ev_addr_match = 0, ev_nack_sent = 0, ev_pec_done = 0;

   logic [9:0]  addr_o;
   logic        dir_rd_o, ten_bit_o, head_only_o, reload_o, auto_end_o;
   logic [7:0]  count_o;
   logic        start_o, stop_o, nack_o, pec_o;
   logic [26:0] rd_data;

   logic [9:0]  n_addr;
   logic        n_dir, n_ten, n_head, n_rld, n_auto, n_start, n_stop, n_nack, n_pec;
   logic [7:0]  n_cnt;
   logic [26:0] n_rd;

   int checks = 0;
   int failures = 0;

   i2c_xfer_ctrl_reg u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .periph_en(periph_en),
      .ev_addr_sent(ev_addr_sent), .ev_arb_lost(ev_arb_lost), .ev_timeout(ev_timeout),
      .ev_start_clr(ev_start_clr), .ev_stop_det(ev_stop_det), .ev_addr_match(ev_addr_match),
      .ev_nack_sent(ev_nack_sent), .ev_pec_done(ev_pec_done),
      .addr_o(addr_o), .dir_rd_o(dir_rd_o), .ten_bit_o(ten_bit_o), .head_only_o(head_only_o),
      .count_o(count_o), .reload_o(reload_o), .auto_end_o(auto_end_o),
      .start_o(start_o), .stop_o(stop_o), .nack_o(nack_o), .pec_o(pec_o), .rd_data(rd_data)
   );

   i2c_xfer_ctrl_reg #(.PEC_SUPPORT(1'b0)) u_nopec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .periph_en(periph_en),
      .ev_addr_sent(ev_addr_sent), .ev_arb_lost(ev_arb_lost), .ev_timeout(ev_timeout),
      .ev_start_clr(ev_start_clr), .ev_stop_det(ev_stop_det), .ev_addr_match(ev_addr_match),
      .ev_nack_sent(ev_nack_sent), .ev_pec_done(ev_pec_done),
      .addr_o(n_addr), .dir_rd_o(n_dir), .ten_bit_o(n_ten), .head_only_o(n_head),
      .count_o(n_cnt), .reload_o(n_rld), .auto_end_o(n_auto),
      .start_o(n_start), .stop_o(n_stop), .nack_o(n_nack), .pec_o(n_pec), .rd_data(n_rd)
   );

   // Layout: {pec, nack, stop, start, auto_end, reload, count[7:0], head, ten, dir, addr[9:0]}
   function automatic logic [26:0] pack(input logic [9:0] a, input logic d, input logic t,
                                        input logic h, input logic [7:0] c, input logic r,
                                        input logic ae, input logic [3:0] cmd);
      return {cmd[3], cmd[2], cmd[1], cmd[0], ae, r, c, h, t, d, a};
   endfunction

   localparam logic [3:0] C_START = 4'b0001, C_STOP = 4'b0010,
                          C_NACK = 4'b0100, C_PEC = 4'b1000;

   task automatic check(input string req, input logic [26:0] act, input logic [26:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [26:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic clear_all_events();
      ev_addr_sent = 0; ev_arb_lost = 0; ev_timeout = 0; ev_start_clr = 0;
      ev_stop_det = 0; ev_addr_match = 0; ev_nack_sent = 0; ev_pec_done = 0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: ev_addr_sent = 1;  1: ev_arb_lost = 1;   2: ev_timeout = 1;
         3: ev_start_clr = 1;  4: ev_stop_det = 1;   5: ev_addr_match = 1;
         6: ev_nack_sent = 1;  default: ev_pec_done = 1;
      endcase
      @(negedge clk);
      clear_all_events();
   endtask

   localparam logic [26:0] CFG_A = pack(10'h2A5, 1'b1, 1'b1, 1'b0, 8'hC3, 1'b0, 1'b1, 4'b0);
   localparam logic [26:0] CFG_B = pack(10'h15A, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b1, 1'b0, 4'b0);

   task automatic t_reset();
      check("R1 reset readback", rd_data, '0);
      check("R1 reset start/stop/nack/pec", {23'b0, start_o, stop_o, nack_o, pec_o}, '0);
   endtask

   task automatic t_cfg_write();
      wr(CFG_A);
      check("R9 config write readback", rd_data, CFG_A);
      check("R12 address field", {17'b0, addr_o}, 27'h2A5);
      check("R12 count field", {19'b0, count_o}, 27'hC3);
      check("R12 mode bits", {22'b0, dir_rd_o, ten_bit_o, head_only_o, reload_o, auto_end_o},
            27'b11001);
   endtask

   task automatic t_set_zero();
      wr(CFG_A | pack(0, 0, 0, 0, 0, 0, 0, C_STOP));
      check("R2 stop set by 1", {26'b0, stop_o}, 27'd1);
      wr(CFG_A);
      check("R2 write 0 keeps stop", rd_data, CFG_A | pack(0, 0, 0, 0, 0, 0, 0, C_STOP));
      pulse(4);
      check("R4 stop cleared by stop detect", {26'b0, stop_o}, 27'd0);
   endtask

   task automatic t_start_events();
      for (int e = 0; e < 4; e++) begin
         wr(CFG_A | pack(0, 0, 0, 0, 0, 0, 0, C_START));
         check("R2 start set", {26'b0, start_o}, 27'd1);
         pulse(e);
         check($sformatf("R3 start cleared by event %0d", e), {26'b0, start_o}, 27'd0);
      end
   endtask

   task automatic t_freeze();
      wr(CFG_A | pack(0, 0, 0, 0, 0, 0, 0, C_START));
      wr(CFG_B);
      // R8: locked fields keep CFG_A; R9: reload=1, auto_end=0 from CFG_B
      check("R8 locked fields held", {10'b0, rd_data[20:0]}, {10'b0, CFG_A[20:0]});
      check("R9 reload/auto-end written while start", {25'b0, rd_data[22:21]}, 27'b01);
      check("R8 start still pending", {26'b0, start_o}, 27'd1);
      pulse(3);
      wr(CFG_B);
      check("R9 config accepted after start clear", rd_data, CFG_B);
   endtask

   task automatic t_nack_pec();
      for (int e = 0; e < 3; e++) begin
         wr(CFG_B | pack(0, 0, 0, 0, 0, 0, 0, C_NACK | C_PEC));
         check("R2 nack and pec set", {25'b0, nack_o, pec_o}, 27'b11);
         check("R11 pec absent reads 0", {26'b0, n_pec}, 27'd0);
         pulse(e == 0 ? 6 : (e == 1 ? 4 : 5));
         if (e == 0) begin
            check("R5 nack cleared by nack sent", {26'b0, nack_o}, 27'd0);
            check("R6 pec unaffected by nack sent", {26'b0, pec_o}, 27'd1);
            pulse(7);
            check("R6 pec cleared by pec done", {26'b0, pec_o}, 27'd0);
         end else begin
            check("R5 R6 nack/pec cleared by stop or match", {25'b0, nack_o, pec_o}, 27'b00);
         end
      end
   endtask

   task automatic t_disable();
      wr(CFG_B | pack(0, 0, 0, 0, 0, 0, 0, C_STOP | C_NACK | C_PEC));
      check("R2 three bits set", {23'b0, pec_o, nack_o, stop_o, start_o}, 27'b1110);
      @(negedge clk); periph_en = 1'b0;
      @(negedge clk);
      check("R7 disable clears commands", {23'b0, pec_o, nack_o, stop_o, start_o}, 27'd0);
      wr(CFG_B | pack(0, 0, 0, 0, 0, 0, 0, 4'hF));
      check("R7 no set while disabled", {23'b0, pec_o, nack_o, stop_o, start_o}, 27'd0);
      @(negedge clk); periph_en = 1'b1;
   endtask

   task automatic t_race();
      @(negedge clk);
      wr_en = 1'b1; wr_data = CFG_B | pack(0, 0, 0, 0, 0, 0, 0, C_START); ev_timeout = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; clear_all_events();
      check("R10 timeout beats start write", {26'b0, start_o}, 27'd0);
      @(negedge clk);
      wr_en = 1'b1; wr_data = CFG_B | pack(0, 0, 0, 0, 0, 0, 0, C_STOP); ev_stop_det = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; clear_all_events();
      check("R10 stop detect beats stop write", {26'b0, stop_o}, 27'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg_write();
      t_set_zero();
      t_start_events();
      t_freeze();
      t_nack_pec();
      t_disable();
      t_race();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule